// File: doc/BRIEF.md
# Masked modulo index update unit

This block produces the next values of two 16-bit index pointers, X and Y, each time a multiply-accumulate step completes. Each pointer moves by a small signed step taken from the instruction: a 4-bit two's-complement value that is sign-extended to the pointer width before it is added. The same datapath serves linear buffers and power-of-two circular buffers.

Each pointer has its own mask register. A set mask bit marks a pointer bit that takes its value from the sum. A clear mask bit marks a pointer bit that is copied unchanged from the old pointer. This gives a circular buffer of size 2^k at any base address aligned to 2^k. An all-zero mask selects a plain wrapping addition, and this is the state after reset. Masks are written by a separate strobe before a repeated accumulate sequence begins. Pointers are initialised through a load strobe and then advanced by the update strobe.

Top module: `masked_index_unit`

## Requirements
- R1: During and after reset both pointer outputs read 0x0000 and both masks are zero, so the first update after reset is a linear addition.
- R2: When `ptr_load_i` is high at a clock edge, both pointers take `ptr_x_i` / `ptr_y_i` at that edge.
- R3: Each 4-bit offset is treated as two's complement: bit 3 set means negative (0xF = -1, 0x8 = -8, 0x7 = +7).
- R4: With a zero mask, an update sets the pointer to (pointer + sign-extended offset) mod 2^16, with no carry out (0xFFFF + 1 = 0x0000).
- R5: With a non-zero mask, an update keeps the pointer bits where the mask is 0 and takes the bits of (pointer + sign-extended offset) where the mask is 1.
- R6: The X and Y pointers use separate masks. A mask written for one pointer has no effect on the other.
- R7: When neither `ptr_load_i` nor `step_i` is high, both pointers hold their value.
- R8: A mask written by `mask_we_i` applies to updates from the next clock edge onward. An update in the same cycle as the write uses the previous mask.
- R9: When `ptr_load_i` and `step_i` are high together, the load wins and the offset is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mask_we_i | input | 1 | Write both mask registers |
| mask_x_i | input | 16 | New X mask |
| mask_y_i | input | 16 | New Y mask |
| ptr_load_i | input | 1 | Load both pointers |
| ptr_x_i | input | 16 | Load value for X |
| ptr_y_i | input | 16 | Load value for Y |
| step_i | input | 1 | Advance both pointers by their offsets |
| off_x_i | input | 4 | Signed step for X |
| off_y_i | input | 4 | Signed step for Y |
| ptr_x_o | output | 16 | Current X pointer |
| ptr_y_o | output | 16 | Current Y pointer |

## Verification
The bench builds the unit with its default parameters: a 16-bit pointer width and a 4-bit offset width. At these values the full offset range from -8 to +7 is covered. The pointer sums can be pushed across 0xFFFF and 0x0000 in both directions, and the masks can be chosen so that wrapping inside a small buffer and wrapping of the whole address space are both tested. Directed sequences cover mask write timing and the load-over-update priority. A long randomized run is then compared every clock against a behavioural model.

// File: rtl/idx_pkg.sv
package idx_pkg;
  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_LOAD = 2'd1,
    PTR_STEP = 2'd2
  } ptr_op_e;
endpackage

// File: rtl/idx_mask_reg.sv
module idx_mask_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/idx_next.sv
module idx_next #(
  parameter int unsigned W  = 16,
  parameter int unsigned OW = 4
) (
  input  logic [W-1:0]  ptr_i,
  input  logic [W-1:0]  mask_i,
  input  logic [OW-1:0] off_i,
  output logic [W-1:0]  next_o
);
  localparam int unsigned EXT_W = W - OW;

  logic [W-1:0] off_ext;
  logic [W-1:0] sum;
  logic         linear;

  assign off_ext = {{EXT_W{off_i[OW-1]}}, off_i};
  assign sum     = ptr_i + off_ext;   // carry out dropped
  assign linear  = (mask_i == '0);

  always_comb begin
    if (linear) next_o = sum;
    else        next_o = (ptr_i & ~mask_i) | (sum & mask_i);
  end
endmodule

// File: rtl/idx_ptr_reg.sv
module idx_ptr_reg
  import idx_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  ptr_op_e      op_i,
  input  logic [W-1:0] load_i,
  input  logic [W-1:0] next_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else begin
      unique case (op_i)
        PTR_LOAD: q_o <= load_i;
        PTR_STEP: q_o <= next_i;
        default:  q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/masked_index_unit.sv
module masked_index_unit
  import idx_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_we_i,
  input  logic [ADDR_W-1:0] mask_x_i,
  input  logic [ADDR_W-1:0] mask_y_i,
  input  logic              ptr_load_i,
  input  logic [ADDR_W-1:0] ptr_x_i,
  input  logic [ADDR_W-1:0] ptr_y_i,
  input  logic              step_i,
  input  logic [OFF_W-1:0]  off_x_i,
  input  logic [OFF_W-1:0]  off_y_i,
  output logic [ADDR_W-1:0] ptr_x_o,
  output logic [ADDR_W-1:0] ptr_y_o
);
  localparam int unsigned LANES = 2;
  localparam int unsigned EXT_W = ADDR_W - OFF_W;

  ptr_op_e op;

  // load has priority over step
  always_comb begin
    if (ptr_load_i)  op = PTR_LOAD;
    else if (step_i) op = PTR_STEP;
    else             op = PTR_HOLD;
  end

  logic [ADDR_W-1:0] mask_d [LANES];
  logic [ADDR_W-1:0] ld_d   [LANES];
  logic [OFF_W-1:0]  off_d  [LANES];
  logic [ADDR_W-1:0] mask_q [LANES];
  logic [ADDR_W-1:0] nxt    [LANES];
  logic [ADDR_W-1:0] ptr_q  [LANES];

  assign mask_d[0] = mask_x_i;
  assign mask_d[1] = mask_y_i;
  assign ld_d[0]   = ptr_x_i;
  assign ld_d[1]   = ptr_y_i;
  assign off_d[0]  = off_x_i;
  assign off_d[1]  = off_y_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    idx_mask_reg #(.W(ADDR_W)) i_mask (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (mask_we_i),
      .d_i    (mask_d[l]),
      .q_o    (mask_q[l])
    );

    idx_next #(.W(ADDR_W), .OW(OFF_W)) i_next (
      .ptr_i  (ptr_q[l]),
      .mask_i (mask_q[l]),
      .off_i  (off_d[l]),
      .next_o (nxt[l])
    );

    idx_ptr_reg #(.W(ADDR_W)) i_ptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .op_i   (op),
      .load_i (ld_d[l]),
      .next_i (nxt[l]),
      .q_o    (ptr_q[l])
    );

    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ptr_load_i && !step_i) |=> $stable(ptr_q[l])); // R7

    AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ptr_load_i |=> ptr_q[l] == $past(ld_d[l])); // R9

    AST_LINEAR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !ptr_load_i && mask_q[l] == '0) |=>
      ptr_q[l] == $past(ptr_q[l] + {{EXT_W{off_d[l][OFF_W-1]}}, off_d[l]})); // R4

    AST_FIXED_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !ptr_load_i && mask_q[l] != '0) |=>
      ((ptr_q[l] ^ $past(ptr_q[l])) & ~$past(mask_q[l])) == '0); // R5

    AST_MASK_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mask_we_i |=> mask_q[l] == $past(mask_d[l])); // R8
  end

  assign ptr_x_o = ptr_q[0];
  assign ptr_y_o = ptr_q[1];
endmodule

// File: tb/test_masked_index_unit.sv
`timescale 1ns/1ps
module test_masked_index_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mask_we_i = 1'b0;
  logic [15:0] mask_x_i = '0, mask_y_i = '0;
  logic        ptr_load_i = 1'b0;
  logic [15:0] ptr_x_i = '0, ptr_y_i = '0;
  logic        step_i = 1'b0;
  logic [3:0]  off_x_i = '0, off_y_i = '0;
  logic [15:0] ptr_x_o, ptr_y_o;

  int checks = 0;
  int fails  = 0;
  int mx = 0, my = 0, px = 0, py = 0;

  always #10 clk = ~clk;

  masked_index_unit i_masked_index_unit (
    .clk_i(clk), .rst_ni(rst_ni),
    .mask_we_i(mask_we_i), .mask_x_i(mask_x_i), .mask_y_i(mask_y_i),
    .ptr_load_i(ptr_load_i), .ptr_x_i(ptr_x_i), .ptr_y_i(ptr_y_i),
    .step_i(step_i), .off_x_i(off_x_i), .off_y_i(off_y_i),
    .ptr_x_o(ptr_x_o), .ptr_y_o(ptr_y_o)
  );

  function automatic int model_next(int p, int m, int o);
    int s, sum;
    s   = (o >= 8) ? o - 16 : o;
    sum = (p + s + 65536) % 65536;
    if (m == 0) return sum;
    return (p & ~m & 16'hFFFF) | (sum & m);
  endfunction

  task automatic expect_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %04h expected %04h", tag, act, exp);
    end
  endtask

  // one clock: model follows inputs at the edge, outputs compared at negedge
  task automatic tick();
    int nx, ny;
    @(posedge clk);
    nx = px; ny = py;
    if (ptr_load_i) begin nx = ptr_x_i; ny = ptr_y_i; end
    else if (step_i) begin
      nx = model_next(px, mx, off_x_i);
      ny = model_next(py, my, off_y_i);
    end
    px = nx; py = ny;
    if (mask_we_i) begin mx = mask_x_i; my = mask_y_i; end
    @(negedge clk);
    expect_eq("model X", ptr_x_o, px);
    expect_eq("model Y", ptr_y_o, py);
  endtask

  task automatic idle();
    mask_we_i = 0; ptr_load_i = 0; step_i = 0;
  endtask

  task automatic load(int x, int y);
    idle(); ptr_load_i = 1; ptr_x_i = x[15:0]; ptr_y_i = y[15:0];
    tick(); idle();
  endtask

  task automatic step(int ox, int oy);
    idle(); step_i = 1; off_x_i = ox[3:0]; off_y_i = oy[3:0];
    tick(); idle();
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #5;
    expect_eq("R1 reset X", ptr_x_o, 0);
    expect_eq("R1 reset Y", ptr_y_o, 0);
    @(negedge clk); @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    expect_eq("R1 after reset X", ptr_x_o, 0);
    // R1: default masks are zero -> linear
    step(3, 3);
    expect_eq("R1 linear default X", ptr_x_o, 16'h0003);
    expect_eq("R1 linear default Y", ptr_y_o, 16'h0003);

    load(16'hFFFF, 16'h0010);
    expect_eq("R2 load X", ptr_x_o, 16'hFFFF);
    expect_eq("R2 load Y", ptr_y_o, 16'h0010);

    step(1, 4'hF);
    expect_eq("R4 wrap X", ptr_x_o, 16'h0000);
    expect_eq("R3 minus one Y", ptr_y_o, 16'h000F);

    step(4'h8, 4'h7);
    expect_eq("R3 minus eight X", ptr_x_o, 16'hFFF8);
    expect_eq("R3 plus seven Y", ptr_y_o, 16'h0016);

    tick(); tick();
    expect_eq("R7 hold X", ptr_x_o, 16'hFFF8);
    expect_eq("R7 hold Y", ptr_y_o, 16'h0016);

    // R8: mask written in same cycle as a step; step uses old (zero) mask
    load(16'h123E, 16'h4006);
    mask_we_i = 1; mask_x_i = 16'h000F; mask_y_i = 16'h0007;
    step_i = 1; off_x_i = 4'h3; off_y_i = 4'h3;
    tick(); idle();
    expect_eq("R8 old mask X", ptr_x_o, 16'h1241);
    expect_eq("R8 old mask Y", ptr_y_o, 16'h4009);

    load(16'h123E, 16'h4006);
    step(3, 3);
    expect_eq("R5 modulo X", ptr_x_o, 16'h1231);
    expect_eq("R5 modulo Y", ptr_y_o, 16'h4001);
    step(4'h8, 4'hF);
    expect_eq("R5 modulo neg X", ptr_x_o, 16'h1239);
    expect_eq("R5 modulo neg Y", ptr_y_o, 16'h4000);
    step(0, 4'hF);
    expect_eq("R5 modulo under Y", ptr_y_o, 16'h4007);

    // R6: clear only the Y mask; X stays circular
    idle(); mask_we_i = 1; mask_x_i = 16'h000F; mask_y_i = 16'h0000;
    tick(); idle();
    load(16'h00FF, 16'h00FF);
    step(1, 1);
    expect_eq("R6 X keeps mask", ptr_x_o, 16'h00F0);
    expect_eq("R6 Y now linear", ptr_y_o, 16'h0100);

    // R9: load and step together
    idle(); ptr_load_i = 1; step_i = 1; ptr_x_i = 16'hA5A5; ptr_y_i = 16'h5A5A;
    off_x_i = 4'h5; off_y_i = 4'h5;
    tick(); idle();
    expect_eq("R9 load wins X", ptr_x_o, 16'hA5A5);
    expect_eq("R9 load wins Y", ptr_y_o, 16'h5A5A);

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 15);
      mask_we_i  = (r == 0);
      ptr_load_i = (r == 1) || (r == 2);
      step_i     = (r >= 2) && (r <= 12);
      mask_x_i   = (($urandom_range(0, 3) == 0) ? 16'h0 : (16'hFFFF >> $urandom_range(0, 15)));
      mask_y_i   = 16'($urandom());
      ptr_x_i    = 16'($urandom());
      ptr_y_i    = 16'($urandom());
      off_x_i    = 4'($urandom());
      off_y_i    = 4'($urandom());
      tick();
    end
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule